// File: doc/BRIEF.md
# High-Voltage Rail Sequencing Controller

This controller brings up and tears down the supplies of a display panel that needs three high-voltage rails: offset, bias and reset. When a projection request arrives, it switches on four low-voltage supplies in a staggered fashion. It then enables the offset rail. After a programmable number of milliseconds it enables the bias rail, and after a second programmable wait it enables the reset rail. At that point it releases the panel reset and reports that the panel is fully powered. Each wait state is timed against a free-running prescaler. The prescaler makes a microsecond tick and a millisecond tick from the system clock, and both rates are parameters, so a test can shrink the millisecond scale.

There are two ways down, and they do not overlap. When the request is withdrawn, the normal shutdown first holds everything for 25 ms. It then stops bias and reset regulation together. Ten milliseconds later it stops offset regulation and pulls the panel reset low. One millisecond after that it discharges all three rails for 1 ms, and then it removes every supply. A fault takes the fast path when the fast-shutdown bit is set. Bias and reset regulation stop after a first coded delay. Offset regulation stops and the discharge begins after a second coded delay. The panel-enable signal drops last. The controller then waits in standby, with only the first two supplies on, until the fault clears. If the request is still present, it restarts from the third supply; otherwise it returns to idle.

All inputs are plain synchronous levels; register fields appear as input ports.

Top module: `hvseq_ctrl`

## Requirements
- R1: While reset is held and just after it, `sup_en` is 0000, all three rail enables, `dischg`, `panel_rst_n`, `panel_en` and `pwr_ready` are 0, and `int_n` is 1.
- R2: From idle, a request (`proj_en`=1 with `fault`=0) sets `sup_en` bits in the order bit0, bit1, bit2, bit3. Each bit is set one STEP_MS wait after the previous one, and the bits stay set as a thermometer code.
- R3: After the bit3 step, `ofs_en` and `panel_en` rise. `bias_en` rises `ofs_ms` milliseconds later. `bias_ms` milliseconds after that, `rrst_en`, `panel_rst_n` and `pwr_ready` rise together.
- R4: When `proj_en` is low in the ready state, the controller holds everything for PRE_MS. It then clears `bias_en` and `rrst_en`. OFS_HOLD_MS later it clears `ofs_en` and `panel_rst_n`. DIS_DLY_MS later it raises `dischg` for NDIS_MS with the supplies still on. It then clears every output.
- R5: `int_n` goes low in the cycle after `fault` is high, and stays low for the whole fast sequence and standby. In a shutdown with no fault, `int_n` stays high throughout.
- R6: A fault in the ready state with `fast_sd_en`=1 clears `bias_en` and `rrst_en` after 4 + floor(17·`fsd_dly1`/4) µs. That is 4 µs at code 0 and 1087 µs at code 255. The suggested setting is code 126, which gives 539 µs.
- R7: After a second wait of 4 + floor(17·`fsd_dly2`/4) µs (4 µs at the suggested code 0), `ofs_en` and `panel_rst_n` fall and `dischg` rises. `panel_en` falls last, FDIS_US µs later, when standby is entered.
- R8: In standby, `sup_en` is 0011 and all other outputs are 0 for as long as `fault` stays high. Once the fault clears, the controller restarts by setting `sup_en` to 0111 and then follows the R2/R3 steps if `proj_en` is 1. If `proj_en` is 0, it returns to idle.
- R9: With `fast_sd_en`=0, a fault in the ready state runs the R4 order and ends in idle, with `sup_en` at 0000. No restart takes place while the fault stays high.
- R10: With `fast_sd_en`=1, a fault during power-up or normal shutdown pre-empts the sequence at the matching fast step:
  - during the supply steps, it goes straight to standby;
  - with offset or offset+bias on (power-up) or bias stopped (shutdown), it skips to the second fast wait;
  - during the 25 ms hold, it enters the first fast wait;
  - after offset has stopped, it goes straight to discharge.
- R11: Dropping `proj_en` during power-up is deferred until the ready state is reached. Raising `proj_en` during a shutdown does not stop it. The sequence completes to idle and then starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proj_en | input | 1 | Projection request level |
| fault | input | 1 | Fault flag, active high |
| fast_sd_en | input | 1 | Selects the fast fault shutdown (set by default in software) |
| ofs_ms | input | 8 | Offset-to-bias wait, ms |
| bias_ms | input | 8 | Bias-to-reset wait, ms |
| fsd_dly1 | input | 8 | Fault-to-regulation-stop code |
| fsd_dly2 | input | 8 | Regulation-stop-to-discharge code |
| sup_en | output | 4 | Low-voltage supply enables, bit0 first |
| ofs_en | output | 1 | Offset rail regulation enable |
| bias_en | output | 1 | Bias rail regulation enable |
| rrst_en | output | 1 | Reset rail regulation enable |
| dischg | output | 1 | Discharge command for all three rails |
| panel_rst_n | output | 1 | Active-low panel reset |
| int_n | output | 1 | Active-low interrupt |
| panel_en | output | 1 | Panel enable |
| pwr_ready | output | 1 | Fully powered indication |

## Verification
The assertions assume that `proj_en`, `fault` and `fast_sd_en` are already synchronous to `clk`. They also assume that the delay fields stay constant while a wait that uses them is in progress. The stimulus changes every input on the falling clock edge, and it changes the fault codes only while the controller is idle or in the ready state. Faults are applied only at points where the pre-emption mapping is defined. Each fault is held for at least one full sequence, so the standby-hold and fault-to-interrupt properties see settled levels.

// File: rtl/hvseq_pkg.sv
package hvseq_pkg;

  typedef enum logic [3:0] {
    S_OFF, S_PWR1, S_PWR2, S_PWR3, S_PWR4, S_OFS, S_BIAS, S_READY,
    S_NDLY, S_NBR, S_NOFS, S_NDIS, S_FD1, S_FD2, S_FDIS, S_STBY
  } seq_st_e;

  typedef struct packed {
    logic [3:0] sup;
    logic       ofs;
    logic       bias;
    logic       rrst;
    logic       dis;
    logic       prst_n;
    logic       pen;
    logic       rdy;
  } rail_t;

  localparam logic [7:0] FD1_CODE_SUGGEST = 8'd126;
  localparam logic [7:0] FD2_CODE_SUGGEST = 8'd0;

  function automatic logic [15:0] fast_wait_us(input logic [7:0] code);
    logic [17:0] prod;
    prod = 18'(code) * 18'd17;
    return 16'd4 + 16'(prod >> 2);
  endfunction

  function automatic logic in_fast(input seq_st_e s);
    return (s == S_FD1) || (s == S_FD2) || (s == S_FDIS) || (s == S_STBY);
  endfunction

endpackage

// File: rtl/hvseq_tick.sv
module hvseq_tick #(
  parameter int US_DIV    = 250,
  parameter int US_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_us,
  output logic tick_ms
);
  localparam int UW = $clog2(US_DIV > 1 ? US_DIV : 2);
  localparam int MW = $clog2(US_PER_MS > 1 ? US_PER_MS : 2);
  localparam logic [UW-1:0] U_LAST = UW'(US_DIV - 1);
  localparam logic [MW-1:0] M_LAST = MW'(US_PER_MS - 1);

  logic [UW-1:0] ucnt;
  logic [MW-1:0] mcnt;

  assign tick_us = (ucnt == U_LAST);
  assign tick_ms = tick_us && (mcnt == M_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucnt <= '0;
      mcnt <= '0;
    end else begin
      ucnt <= tick_us ? '0 : ucnt + 1'b1;
      if (tick_us) mcnt <= tick_ms ? '0 : mcnt + 1'b1;
    end
  end

  generate
    if (US_DIV > 1) begin : g_chk
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_us |=> !tick_us);
    end
  endgenerate
endmodule

// File: rtl/hvseq_timer.sv
module hvseq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic          tick_ms,
  input  logic          load,
  input  logic          load_ms,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;
  logic          unit_ms;
  logic          step;

  assign step = unit_ms ? tick_ms : tick_us;
  assign done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      unit_ms <= 1'b1;
    end else if (load) begin
      cnt     <= load_val;
      unit_ms <= load_ms;
    end else if (step && !done) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/hvseq_decode.sv
module hvseq_decode
  import hvseq_pkg::*;
(
  input  seq_st_e st,
  output rail_t   o
);
  always_comb begin
    o = '0;
    unique case (st)
      S_OFF:   o = '0;
      S_PWR1:  o.sup = 4'b0001;
      S_PWR2:  o.sup = 4'b0011;
      S_PWR3:  o.sup = 4'b0111;
      S_PWR4:  o.sup = 4'b1111;
      S_OFS:   begin o.sup = 4'b1111; o.ofs = 1'b1; o.pen = 1'b1; end
      S_BIAS:  begin o.sup = 4'b1111; o.ofs = 1'b1; o.bias = 1'b1; o.pen = 1'b1; end
      S_READY: begin
        o.sup = 4'b1111; o.ofs = 1'b1; o.bias = 1'b1; o.rrst = 1'b1;
        o.prst_n = 1'b1; o.pen = 1'b1; o.rdy = 1'b1;
      end
      S_NDLY, S_FD1: begin
        o.sup = 4'b1111; o.ofs = 1'b1; o.bias = 1'b1; o.rrst = 1'b1;
        o.prst_n = 1'b1; o.pen = 1'b1;
      end
      S_NBR, S_FD2: begin
        o.sup = 4'b1111; o.ofs = 1'b1; o.prst_n = 1'b1; o.pen = 1'b1;
      end
      S_NOFS:  begin o.sup = 4'b1111; o.pen = 1'b1; end
      S_NDIS, S_FDIS: begin o.sup = 4'b1111; o.dis = 1'b1; o.pen = 1'b1; end
      S_STBY:  o.sup = 4'b0011;
      default: o = '0;
    endcase
  end
endmodule

// File: rtl/hvseq_ctrl.sv
module hvseq_ctrl
  import hvseq_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int US_PER_MS   = 1000,
  parameter int STEP_MS     = 1,
  parameter int PRE_MS      = 25,
  parameter int OFS_HOLD_MS = 10,
  parameter int DIS_DLY_MS  = 1,
  parameter int NDIS_MS     = 1,
  parameter int FDIS_US     = 4,
  parameter int TW          = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       proj_en,
  input  logic       fault,
  input  logic       fast_sd_en,
  input  logic [7:0] ofs_ms,
  input  logic [7:0] bias_ms,
  input  logic [7:0] fsd_dly1,
  input  logic [7:0] fsd_dly2,
  output logic [3:0] sup_en,
  output logic       ofs_en,
  output logic       bias_en,
  output logic       rrst_en,
  output logic       dischg,
  output logic       panel_rst_n,
  output logic       int_n,
  output logic       panel_en,
  output logic       pwr_ready
);
  localparam int US_DIV = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;

  seq_st_e        st, nxt;
  logic           tick_us, tick_ms, tmr_done;
  logic           ld, ld_ms;
  logic [TW-1:0]  ld_val;
  logic           ffast;
  logic           int_q;
  rail_t          ro;

  hvseq_tick #(.US_DIV(US_DIV), .US_PER_MS(US_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .tick_ms(tick_ms));

  hvseq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .tick_ms(tick_ms),
    .load(ld), .load_ms(ld_ms), .load_val(ld_val), .done(tmr_done));

  hvseq_decode u_dec (.st(st), .o(ro));

  assign ffast = fault && fast_sd_en;

  always_comb begin
    nxt = st;
    unique case (st)
      S_OFF:   if (proj_en && !fault) nxt = S_PWR1;
      S_PWR1:  if (ffast) nxt = S_STBY; else if (tmr_done) nxt = S_PWR2;
      S_PWR2:  if (ffast) nxt = S_STBY; else if (tmr_done) nxt = S_PWR3;
      S_PWR3:  if (ffast) nxt = S_STBY; else if (tmr_done) nxt = S_PWR4;
      S_PWR4:  if (ffast) nxt = S_STBY; else if (tmr_done) nxt = S_OFS;
      S_OFS:   if (ffast) nxt = S_FD2;  else if (tmr_done) nxt = S_BIAS;
      S_BIAS:  if (ffast) nxt = S_FD2;  else if (tmr_done) nxt = S_READY;
      S_READY: if (ffast) nxt = S_FD1;  else if (!proj_en || fault) nxt = S_NDLY;
      S_NDLY:  if (ffast) nxt = S_FD1;  else if (tmr_done) nxt = S_NBR;
      S_NBR:   if (ffast) nxt = S_FD2;  else if (tmr_done) nxt = S_NOFS;
      S_NOFS:  if (ffast) nxt = S_FDIS; else if (tmr_done) nxt = S_NDIS;
      S_NDIS:  if (tmr_done) nxt = S_OFF;
      S_FD1:   if (tmr_done) nxt = S_FD2;
      S_FD2:   if (tmr_done) nxt = S_FDIS;
      S_FDIS:  if (tmr_done) nxt = S_STBY;
      S_STBY:  if (!fault) nxt = proj_en ? S_PWR3 : S_OFF;
      default: nxt = S_OFF;
    endcase
  end

  always_comb begin
    ld     = (nxt != st);
    ld_ms  = 1'b1;
    ld_val = '0;
    unique case (nxt)
      S_PWR1, S_PWR2, S_PWR3, S_PWR4: ld_val = TW'(STEP_MS);
      S_OFS:   ld_val = TW'(ofs_ms);
      S_BIAS:  ld_val = TW'(bias_ms);
      S_NDLY:  ld_val = TW'(PRE_MS);
      S_NBR:   ld_val = TW'(OFS_HOLD_MS);
      S_NOFS:  ld_val = TW'(DIS_DLY_MS);
      S_NDIS:  ld_val = TW'(NDIS_MS);
      S_FD1:   begin ld_ms = 1'b0; ld_val = TW'(fast_wait_us(fsd_dly1)); end
      S_FD2:   begin ld_ms = 1'b0; ld_val = TW'(fast_wait_us(fsd_dly2)); end
      S_FDIS:  begin ld_ms = 1'b0; ld_val = TW'(FDIS_US); end
      default: ld_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      int_q <= 1'b1;
    end else begin
      st    <= nxt;
      int_q <= !(fault || in_fast(st));
    end
  end

  assign sup_en      = ro.sup;
  assign ofs_en      = ro.ofs;
  assign bias_en     = ro.bias;
  assign rrst_en     = ro.rrst;
  assign dischg      = ro.dis;
  assign panel_rst_n = ro.prst_n;
  assign panel_en    = ro.pen;
  assign pwr_ready   = ro.rdy;
  assign int_n       = int_q;

  assert_sup_thermo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_en & (sup_en + 4'd1)) == 4'd0);
  assert_ofs_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFS && !tmr_done && !fault) |=> (st == S_OFS));
  assert_dis_no_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dischg |-> !(ofs_en || bias_en || rrst_en));
  assert_fault_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !int_n);
  assert_ready_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ready && fault && fast_sd_en) |=> (bias_en && !pwr_ready && !int_n));
  assert_stby_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STBY && fault) |=> (sup_en == 4'b0011));
endmodule

// File: tb/hvseq_ctrl_test.sv
module hvseq_ctrl_test;
  localparam int CLKHZ = 2_000_000;
  localparam int USD   = 2;
  localparam int UPM   = 20;
  localparam int MSC   = USD * UPM;

  localparam int M_OFF = 0, M_P1 = 1, M_P2 = 2, M_P3 = 3, M_P4 = 4, M_OFS = 5,
                 M_BIAS = 6, M_RDY = 7, M_NDLY = 8, M_NBR = 9, M_NOFS = 10,
                 M_NDIS = 11, M_FD1 = 12, M_FD2 = 13, M_FDIS = 14, M_STBY = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic proj_en = 1'b0, fault = 1'b0, fast_sd_en = 1'b1;
  logic [7:0] ofs_ms = 8'd2, bias_ms = 8'd3, fsd_dly1 = 8'd126, fsd_dly2 = 8'd0;
  logic [3:0] sup_en;
  logic ofs_en, bias_en, rrst_en, dischg, panel_rst_n, int_n, panel_en, pwr_ready;

  hvseq_ctrl #(.CLK_HZ(CLKHZ), .US_PER_MS(UPM)) uut (
    .clk(clk), .rst_n(rst_n), .proj_en(proj_en), .fault(fault),
    .fast_sd_en(fast_sd_en), .ofs_ms(ofs_ms), .bias_ms(bias_ms),
    .fsd_dly1(fsd_dly1), .fsd_dly2(fsd_dly2), .sup_en(sup_en),
    .ofs_en(ofs_en), .bias_en(bias_en), .rrst_en(rrst_en), .dischg(dischg),
    .panel_rst_n(panel_rst_n), .int_n(int_n), .panel_en(panel_en),
    .pwr_ready(pwr_ready));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: prescaler, wait counter and sequence as integers
  int m_st, m_uc, m_mc, m_cnt;
  bit m_ums, m_int;

  function automatic int wait_len(input int s, output bit ums);
    ums = 1;
    case (s)
      M_P1, M_P2, M_P3, M_P4: return 1;
      M_OFS: return ofs_ms;
      M_BIAS: return bias_ms;
      M_NDLY: return 25;
      M_NBR: return 10;
      M_NOFS, M_NDIS: return 1;
      M_FD1: begin ums = 0; return 4 + (fsd_dly1 * 17) / 4; end
      M_FD2: begin ums = 0; return 4 + (fsd_dly2 * 17) / 4; end
      M_FDIS: begin ums = 0; return 4; end
      default: return 0;
    endcase
  endfunction

  function automatic int step_of(input int s, input bit dn);
    bit ff = fault && fast_sd_en;
    case (s)
      M_OFF: return (proj_en && !fault) ? M_P1 : M_OFF;
      M_P1, M_P2, M_P3, M_P4: return ff ? M_STBY : (dn ? s + 1 : s);
      M_OFS, M_BIAS: return ff ? M_FD2 : (dn ? s + 1 : s);
      M_RDY: return ff ? M_FD1 : ((!proj_en || fault) ? M_NDLY : M_RDY);
      M_NDLY: return ff ? M_FD1 : (dn ? M_NBR : s);
      M_NBR: return ff ? M_FD2 : (dn ? M_NOFS : s);
      M_NOFS: return ff ? M_FDIS : (dn ? M_NDIS : s);
      M_NDIS: return dn ? M_OFF : s;
      M_FD1, M_FD2: return dn ? s + 1 : s;
      M_FDIS: return dn ? M_STBY : s;
      default: return fault ? M_STBY : (proj_en ? M_P3 : M_OFF);
    endcase
  endfunction

  // {sup[3:0], ofs, bias, rrst, dis, prst_n, pen, rdy}
  function automatic logic [10:0] outs_of(input int s);
    case (s)
      M_P1: return 11'b0001_0000000;
      M_P2: return 11'b0011_0000000;
      M_P3: return 11'b0111_0000000;
      M_P4: return 11'b1111_0000000;
      M_OFS: return 11'b1111_1000010;
      M_BIAS: return 11'b1111_1100010;
      M_RDY: return 11'b1111_1110111;
      M_NDLY, M_FD1: return 11'b1111_1110110;
      M_NBR, M_FD2: return 11'b1111_1000110;
      M_NOFS: return 11'b1111_0000010;
      M_NDIS, M_FDIS: return 11'b1111_0001010;
      M_STBY: return 11'b0011_0000000;
      default: return 11'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_OFF; m_uc = 0; m_mc = 0; m_cnt = 0; m_ums = 1; m_int = 1;
    end else begin
      bit tu, tm, nu;
      int nx;
      cyc++;
      tu = (m_uc == USD - 1);
      tm = tu && (m_mc == UPM - 1);
      nx = step_of(m_st, m_cnt == 0);
      m_int = !(fault || m_st >= M_FD1);
      if (nx != m_st) begin
        m_cnt = wait_len(nx, nu);
        m_ums = nu;
      end else if ((m_ums ? tm : tu) && m_cnt != 0) m_cnt--;
      if (tu) m_mc = tm ? 0 : m_mc + 1;
      m_uc = tu ? 0 : m_uc + 1;
      m_st = nx;
    end
  end

  // per-cycle comparison and edge timestamps
  logic [10:0] act, expv;
  bit p_bias = 0, p_ofs = 0, int_low_seen = 0, bias_seen = 0;
  int t_bias_rise, t_ofs_rise, t_bias_fall, t_ofs_fall, t_fault;
  int t_sup[4];

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      act  = {sup_en, ofs_en, bias_en, rrst_en, dischg, panel_rst_n, panel_en, pwr_ready};
      expv = outs_of(m_st);
      chk(act[10:7] == expv[10:7], "R2 sup_en", int'(act[10:7]), int'(expv[10:7]));
      chk({act[6:4], act[0]} == {expv[6:4], expv[0]}, "R3 rails/ready",
          int'({act[6:4], act[0]}), int'({expv[6:4], expv[0]}));
      chk(act[3:2] == expv[3:2], "R4 dischg/panel_rst_n", int'(act[3:2]), int'(expv[3:2]));
      chk(act[1] == expv[1], "R7 panel_en", int'(act[1]), int'(expv[1]));
      chk(int_n == m_int, "R5 int_n", int'(int_n), int'(m_int));
      if (!int_n) int_low_seen = 1;
      if (bias_en) bias_seen = 1;
      if (bias_en && !p_bias) t_bias_rise = cyc;
      if (!bias_en && p_bias) t_bias_fall = cyc;
      if (ofs_en && !p_ofs) t_ofs_rise = cyc;
      if (!ofs_en && p_ofs) t_ofs_fall = cyc;
      for (int i = 0; i < 4; i++) if (sup_en[i] && t_sup[i] < 0) t_sup[i] = cyc;
      p_bias = bias_en;
      p_ofs  = ofs_en;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) t_sup[i] = -1;
    tick(3);
    chk({sup_en, ofs_en, bias_en, rrst_en, dischg, panel_rst_n, panel_en, pwr_ready} == 11'b0
        && int_n, "R1 held", int'({sup_en, ofs_en, bias_en, panel_en}), 0);
    rst_n = 1'b1;
    tick(5);
    chk(sup_en == 4'b0 && int_n && !panel_rst_n && !pwr_ready, "R1 idle", int'(sup_en), 0);

    // normal power-up
    proj_en = 1'b1;
    while (!pwr_ready) tick(1);
    chk(t_sup[0] < t_sup[1] && t_sup[1] < t_sup[2] && t_sup[2] < t_sup[3], "R2 order",
        t_sup[3] - t_sup[0], 3 * MSC);
    chk(t_bias_rise - t_ofs_rise >= MSC && t_bias_rise - t_ofs_rise <= 2 * MSC + 2,
        "R3 offset-to-bias", t_bias_rise - t_ofs_rise, 2 * MSC);
    chk(rrst_en && panel_rst_n, "R3 reset rail", int'({rrst_en, panel_rst_n}), 3);

    // normal shutdown
    tick(10);
    int_low_seen = 0;
    proj_en = 1'b0;
    while (sup_en != 4'b0) tick(1);
    chk(t_ofs_fall - t_bias_fall >= 9 * MSC && t_ofs_fall - t_bias_fall <= 10 * MSC + 2,
        "R4 bias-to-offset stop", t_ofs_fall - t_bias_fall, 10 * MSC);
    chk(!int_low_seen, "R5 no interrupt in normal shutdown", int'(int_low_seen), 0);

    // R11: request drop during power-up is deferred
    proj_en = 1'b1;
    while (sup_en != 4'b0011) tick(1);
    proj_en = 1'b0;
    while (!pwr_ready && sup_en != 4'b0) tick(1);
    chk(pwr_ready, "R11 power-up completes", int'(pwr_ready), 1);
    while (bias_en) tick(1);
    proj_en = 1'b1;
    tick(3);
    chk(!bias_en && ofs_en, "R11 shutdown continues", int'(bias_en), 0);
    while (sup_en != 4'b0) tick(1);
    chk(sup_en == 4'b0, "R11 reaches idle", int'(sup_en), 0);
    while (!pwr_ready) tick(1);

    // fast shutdown from ready, restart
    tick(7);
    fault = 1'b1;
    t_fault = cyc;
    while (!(sup_en == 4'b0011 && !panel_en)) tick(1);
    chk(t_bias_fall - t_fault >= 2 * 539 - 2 && t_bias_fall - t_fault <= 2 * 539 + 3,
        "R6 first fast wait", t_bias_fall - t_fault, 2 * 539);
    chk(t_ofs_fall - t_bias_fall >= 6 && t_ofs_fall - t_bias_fall <= 10,
        "R7 second fast wait", t_ofs_fall - t_bias_fall, 8);
    chk(!int_n, "R5 interrupt on fault", int'(int_n), 0);
    tick(200);
    chk(sup_en == 4'b0011 && !ofs_en && !dischg, "R8 standby holds", int'(sup_en), 3);
    fault = 1'b0;
    tick(2);
    chk(sup_en == 4'b0111, "R8 restart at third supply", int'(sup_en), 7);
    while (!pwr_ready) tick(1);

    // longest codes, fault cleared with request low
    fsd_dly1 = 8'd255; fsd_dly2 = 8'd20;
    fault = 1'b1;
    t_fault = cyc;
    while (!(sup_en == 4'b0011 && !panel_en)) tick(1);
    chk(t_bias_fall - t_fault >= 2 * 1087 - 2 && t_bias_fall - t_fault <= 2 * 1087 + 3,
        "R6 full-scale wait", t_bias_fall - t_fault, 2 * 1087);
    proj_en = 1'b0;
    fault = 1'b0;
    tick(3);
    chk(sup_en == 4'b0 && int_n, "R8 return to idle", int'(sup_en), 0);

    // fast shutdown disabled
    fsd_dly1 = 8'd126; fsd_dly2 = 8'd0;
    fast_sd_en = 1'b0;
    proj_en = 1'b1;
    while (!pwr_ready) tick(1);
    fault = 1'b1;
    while (sup_en != 4'b0) tick(1);
    chk(t_ofs_fall - t_bias_fall >= 9 * MSC, "R9 normal order on fault",
        t_ofs_fall - t_bias_fall, 10 * MSC);
    tick(100);
    chk(sup_en == 4'b0 && !int_n, "R9 no restart while faulted", int'(sup_en), 0);
    fault = 1'b0;
    while (!pwr_ready) tick(1);

    // pre-emption during power-up
    fast_sd_en = 1'b1;
    proj_en = 1'b0;
    while (sup_en != 4'b0) tick(1);
    proj_en = 1'b1;
    while (!ofs_en) tick(1);
    bias_seen = 0;
    fault = 1'b1;
    while (!(sup_en == 4'b0011 && !panel_en)) tick(1);
    chk(!bias_seen, "R10 offset-only pre-empt", int'(bias_seen), 0);
    proj_en = 1'b0;
    fault = 1'b0;
    tick(3);
    proj_en = 1'b1;
    while (sup_en != 4'b0011) tick(1);
    fault = 1'b1;
    tick(3);
    chk(sup_en == 4'b0011 && !panel_en && !int_n, "R10 supply-step pre-empt",
        int'(sup_en), 3);
    fault = 1'b0;
    proj_en = 1'b0;
    tick(5);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule